// File: doc/BRIEF.md
# Triggered Single-Beat Write Master

This block turns a software-held start level into exactly one write transaction on an AXI4-Lite write channel set. A rising edge of the start level launches the write. The address comes from an upstream address-translation datapath. The data word is forwarded from a software register. The block captures both at launch, drives the address and data channels, waits for the slave's write response, and then reports completion with a one-cycle pulse and an error flag.

Software arms the block by taking the start bit high and re-arms it by taking the bit low again. Holding the bit high never produces a second write. An edge that arrives while a write is still in flight is dropped. The address and data channels are raised together and each retires on its own handshake. The response channel is opened only after both have retired.

Top module: `lite_write_issuer`

## Requirements
- R1: A start edge launches a write. An edge is start high at a clock edge after it was low at the previous edge. From the next cycle, `m_awvalid` and `m_wvalid` are both high. `m_awaddr` and `m_wdata` equal the `xlat_addr` and `fwd_data` values sampled at the launching edge.
- R2: Holding `start` high launches only one write. A further write needs `start` to be low for at least one clock edge and then high again.
- R3: A start edge that occurs while a write is in flight (between launch and the response being accepted) is ignored and causes no later write.
- R4: `m_awvalid` stays high and `m_awaddr` stays unchanged until a clock edge at which `m_awready` is high. `m_awvalid` is low in the cycle after that edge.
- R5: `m_wvalid` stays high and `m_wdata` stays unchanged until a clock edge at which `m_wready` is high. `m_wvalid` is low in the cycle after that edge.
- R6: `m_bready` rises in the cycle after the later of the two handshakes (address and data) and is never high while either valid is high. It falls in the cycle after an edge with `m_bvalid` and `m_bready` both high.
- R7: `done` is high for exactly the one cycle after the edge at which the write response is accepted, and is low otherwise.
- R8: `err` is updated when the response is accepted. It is set to 1 if `m_bresp` is not 2'b00 (OKAY) and to 0 if it is OKAY, and it holds that value until the next accepted response.
- R9: `m_awprot` is always 3'b000 and `m_wstrb` is always all ones.
- R10: While the synchronous active-high `rst` is sampled high, the block returns to idle with `m_awvalid`, `m_wvalid`, `m_bready`, `done` and `err` low in the following cycle. The stored previous start level is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start level from the software control bit |
| xlat_addr | input | ADDR_W | Translated write address |
| fwd_data | input | DATA_W | Data word to write |
| m_awaddr | output | ADDR_W | Write address |
| m_awprot | output | 3 | Protection type, fixed to 3'b000 |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready from the slave |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte strobes, all ones |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready from the slave |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| done | output | 1 | One-cycle pulse when the response is accepted |
| err | output | 1 | Last accepted response was not OKAY |

## Verification
The bench drives a slave whose address, data and response delays are skewed against each other. A design that tied the two valids together would hold one channel after its handshake, and one that opened the response channel early would raise `m_bready` while a valid is still high. It holds the start bit high long after completion and pulses it during a slow write, which catches a level-triggered or non-blocking launch as extra address handshakes. It changes the address and data inputs mid-flight, which exposes a pass-through instead of a capture. It also alternates error and OKAY responses, so that a sticky or inverted error flag shows up.

// File: rtl/lwi_pkg.sv
package lwi_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_XFER = 2'd1,
        PH_RESP = 2'd2
    } phase_e;

    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam logic [2:0] PROT_PLAIN = 3'b000;

    function automatic logic resp_failed(input logic [1:0] code);
        return code != RESP_OKAY;
    endfunction

endpackage

// File: rtl/lwi_rise_det.sv
module lwi_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic pulse
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    assign pulse = lvl & ~lvl_q;
endmodule

// File: rtl/lwi_chan_hold.sv
module lwi_chan_hold #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         launch,
    input  logic [W-1:0] payload_in,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] payload,
    output logic         pending
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid   <= 1'b0;
            payload <= '0;
        end else if (launch) begin
            valid   <= 1'b1;
            payload <= payload_in;
        end else if (valid && ready) begin
            valid   <= 1'b0;
        end
    end

    assign pending = valid & ~ready;
endmodule

// File: rtl/lwi_resp_stage.sv
module lwi_resp_stage
    import lwi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       arm,
    input  logic       bvalid,
    input  logic [1:0] bresp,
    output logic       bready,
    output logic       done,
    output logic       err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bready <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (arm) begin
                bready <= 1'b1;
            end else if (bready && bvalid) begin
                bready <= 1'b0;
                done   <= 1'b1;
                err    <= resp_failed(bresp);
            end
        end
    end
endmodule

// File: rtl/lite_write_issuer.sv
module lite_write_issuer
    import lwi_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [ADDR_W-1:0]     xlat_addr,
    input  logic [DATA_W-1:0]     fwd_data,
    output logic [ADDR_W-1:0]     m_awaddr,
    output logic [2:0]            m_awprot,
    output logic                  m_awvalid,
    input  logic                  m_awready,
    output logic [DATA_W-1:0]     m_wdata,
    output logic [DATA_W/8-1:0]   m_wstrb,
    output logic                  m_wvalid,
    input  logic                  m_wready,
    input  logic [1:0]            m_bresp,
    input  logic                  m_bvalid,
    output logic                  m_bready,
    output logic                  done,
    output logic                  err
);
    localparam int STRB_W = DATA_W / 8;

    phase_e phase;
    logic   edge_seen, launch, aw_left, w_left, chans_clear, resp_take;

    lwi_rise_det u_edge (
        .clk(clk), .rst(rst), .lvl(start), .pulse(edge_seen)
    );

    assign launch = edge_seen && (phase == PH_IDLE);

    lwi_chan_hold #(.W(ADDR_W)) u_aw (
        .clk(clk), .rst(rst), .launch(launch), .payload_in(xlat_addr),
        .ready(m_awready), .valid(m_awvalid), .payload(m_awaddr), .pending(aw_left)
    );

    lwi_chan_hold #(.W(DATA_W)) u_w (
        .clk(clk), .rst(rst), .launch(launch), .payload_in(fwd_data),
        .ready(m_wready), .valid(m_wvalid), .payload(m_wdata), .pending(w_left)
    );

    assign chans_clear = (phase == PH_XFER) && !aw_left && !w_left;
    assign resp_take   = (phase == PH_RESP) && m_bready && m_bvalid;

    lwi_resp_stage u_resp (
        .clk(clk), .rst(rst), .arm(chans_clear), .bvalid(m_bvalid),
        .bresp(m_bresp), .bready(m_bready), .done(done), .err(err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: if (launch)      phase <= PH_XFER;
                PH_XFER: if (chans_clear) phase <= PH_RESP;
                PH_RESP: if (resp_take)   phase <= PH_IDLE;
                default:                  phase <= PH_IDLE;
            endcase
        end
    end

    assign m_awprot = PROT_PLAIN;
    assign m_wstrb  = {STRB_W{1'b1}};
endmodule

// File: rtl/lwi_checker.sv
module lwi_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] m_awaddr,
    input logic              m_awvalid,
    input logic              m_awready,
    input logic [DATA_W-1:0] m_wdata,
    input logic              m_wvalid,
    input logic              m_wready,
    input logic              m_bvalid,
    input logic              m_bready,
    input logic              done
);
    p_pair_launch_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(m_awvalid) |-> $rose(m_wvalid));

    p_aw_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

    p_aw_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (m_awvalid && m_awready) |=> !m_awvalid);

    p_w_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata)));

    p_w_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (m_wvalid && m_wready) |=> !m_wvalid);

    p_bready_gap_r6: assert property (@(posedge clk) disable iff (rst)
        m_bready |-> (!m_awvalid && !m_wvalid));

    p_bready_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (m_bready && m_bvalid) |=> !m_bready);

    p_done_src_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(m_bready && m_bvalid));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_quiet_reset_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!m_awvalid && !m_wvalid && !m_bready && !done));
endmodule

bind lite_write_issuer lwi_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lwi_checker (
    .clk(clk), .rst(rst), .m_awaddr(m_awaddr), .m_awvalid(m_awvalid),
    .m_awready(m_awready), .m_wdata(m_wdata), .m_wvalid(m_wvalid),
    .m_wready(m_wready), .m_bvalid(m_bvalid), .m_bready(m_bready), .done(done)
);

// File: tb/lite_write_issuer_test.sv
`timescale 1ns/100ps
module lite_write_issuer_test;
    localparam int AW = 32;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst = 1'b1, start = 1'b0;
    logic [AW-1:0] xlat_addr = '0;
    logic [DW-1:0] fwd_data = '0;
    logic [AW-1:0] m_awaddr;
    logic [2:0]    m_awprot;
    logic          m_awvalid, m_wvalid, m_bready, done, err;
    logic          m_awready = 1'b0, m_wready = 1'b0, m_bvalid = 1'b0;
    logic [DW-1:0] m_wdata;
    logic [DW/8-1:0] m_wstrb;
    logic [1:0]    m_bresp = 2'b00;

    lite_write_issuer #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .start(start), .xlat_addr(xlat_addr), .fwd_data(fwd_data),
        .m_awaddr(m_awaddr), .m_awprot(m_awprot), .m_awvalid(m_awvalid), .m_awready(m_awready),
        .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
        .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready), .done(done), .err(err)
    );

    int tests = 0, fails = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- slave model ----------------
    int aw_dly = 0, w_dly = 0, b_dly = 0;
    logic [1:0] resp_cfg = 2'b00;
    int aw_hs = 0, w_hs = 0, b_hs = 0;
    logic [AW-1:0] got_addr = '0;
    logic [DW-1:0] got_data = '0;

    always @(posedge clk) begin
        if (!rst) begin
            if (m_awvalid && m_awready) begin aw_hs++; got_addr = m_awaddr; end
            if (m_wvalid && m_wready)   begin w_hs++;  got_data = m_wdata;  end
            if (m_bvalid && m_bready)   b_hs++;
        end
    end

    int aw_cnt = 0, w_cnt = 0, b_cnt = 0;
    always @(negedge clk) begin
        if (m_awvalid) begin
            m_awready = (aw_cnt >= aw_dly);
            if (aw_cnt < aw_dly) aw_cnt++;
        end else begin m_awready = 1'b0; aw_cnt = 0; end
        if (m_wvalid) begin
            m_wready = (w_cnt >= w_dly);
            if (w_cnt < w_dly) w_cnt++;
        end else begin m_wready = 1'b0; w_cnt = 0; end
        if (aw_hs > b_hs && w_hs > b_hs) begin
            m_bvalid = (b_cnt >= b_dly);
            m_bresp  = resp_cfg;
            if (b_cnt < b_dly) b_cnt++;
        end else begin m_bvalid = 1'b0; b_cnt = 0; end
    end

    // ---------------- reference model ----------------
    int            ph = 0;
    logic          prev_start = 1'b0;
    logic          e_aw = 0, e_w = 0, e_b = 0, e_done = 0, e_err = 0;
    logic [AW-1:0] e_addr = '0;
    logic [DW-1:0] e_data = '0;

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; prev_start = 0; e_aw = 0; e_w = 0; e_b = 0; e_done = 0; e_err = 0;
            e_addr = '0; e_data = '0;
        end else begin
            e_done = 0;
            if (ph == 0) begin
                if (start && !prev_start) begin
                    e_aw = 1; e_w = 1; e_addr = xlat_addr; e_data = fwd_data; ph = 1;
                end
            end else if (ph == 1) begin
                if (e_aw && m_awready) e_aw = 0;
                if (e_w && m_wready)   e_w = 0;
                if (!e_aw && !e_w) begin e_b = 1; ph = 2; end
            end else begin
                if (m_bvalid) begin
                    e_b = 0; e_done = 1; e_err = (m_bresp != 2'b00); ph = 0;
                end
            end
            prev_start = start;
        end
    end

    always @(posedge clk) begin
        #1;
        chk("R1/R4 awvalid", m_awvalid, e_aw);
        chk("R5 wvalid", m_wvalid, e_w);
        chk("R4 awaddr", m_awaddr, e_addr);
        chk("R5 wdata", m_wdata, e_data);
        chk("R6 bready", m_bready, e_b);
        chk("R7 done", done, e_done);
        chk("R8 err", err, e_err);
        chk("R9 awprot", m_awprot, 3'b000);
        chk("R9 wstrb", m_wstrb, {(DW/8){1'b1}});
    end

    // ---------------- scenarios ----------------
    task automatic write_one(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic exp_err, input string tag);
        int base;
        base = aw_hs;
        @(negedge clk); xlat_addr = a; fwd_data = d; start = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (done) break;
        end
        chk({tag, " R7 done seen"}, done, 1'b1);
        chk({tag, " R1 slave address"}, got_addr, a);
        chk({tag, " R1 slave data"}, got_data, d);
        chk({tag, " R8 err"}, err, exp_err);
        chk({tag, " R2 single write"}, aw_hs - base, 1);
        @(negedge clk); start = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 awvalid in reset", m_awvalid, 0);
        chk("R10 wvalid in reset", m_wvalid, 0);
        chk("R10 bready in reset", m_bready, 0);
        chk("R10 done/err in reset", {done, err}, 2'b00);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        write_one(32'h1234_5678, 32'hCAFE_0001, 1'b0, "fast");
        aw_dly = 4; write_one(32'h0000_0040, 32'h0000_00AA, 1'b0, "aw late");
        aw_dly = 0; w_dly = 5; b_dly = 3;
        write_one(32'hFFFF_FFFC, 32'h5555_AAAA, 1'b0, "w late");
        w_dly = 1; b_dly = 0; resp_cfg = 2'b10;
        write_one(32'h8000_0000, 32'h0BAD_0BAD, 1'b1, "slverr");
        repeat (5) @(negedge clk);
        chk("R8 err held", err, 1'b1);
        resp_cfg = 2'b00; write_one(32'h0000_1000, 32'h1, 1'b0, "okay after err");
        resp_cfg = 2'b11; write_one(32'h0000_2000, 32'h2, 1'b1, "decerr");
        resp_cfg = 2'b00;

        // R2: hold start high long after completion
        begin
            int base;
            base = aw_hs;
            @(negedge clk); xlat_addr = 32'hA0; fwd_data = 32'hB0; start = 1'b1;
            repeat (40) @(negedge clk);
            chk("R2 held start one write", aw_hs - base, 1);
            start = 1'b0; @(negedge clk); start = 1'b1;
            repeat (20) @(negedge clk);
            chk("R2 re-armed second write", aw_hs - base, 2);
            start = 1'b0; repeat (2) @(negedge clk);
        end

        // R3/R4: edge during flight ignored, address captured at launch
        begin
            int base;
            base = aw_hs;
            aw_dly = 10; w_dly = 8;
            @(negedge clk); xlat_addr = 32'h0000_0C00; fwd_data = 32'h77; start = 1'b1;
            repeat (2) @(negedge clk); start = 1'b0;
            xlat_addr = 32'hDEAD_0000; fwd_data = 32'h99;
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (40) @(negedge clk);
            chk("R3 in-flight edge ignored", aw_hs - base, 1);
            chk("R4 address captured at launch", got_addr, 32'h0000_0C00);
            chk("R5 data captured at launch", got_data, 32'h77);
            aw_dly = 0; w_dly = 0;
        end

        // R10: reset in the middle of a write
        b_dly = 20;
        @(negedge clk); xlat_addr = 32'h44; start = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b1; start = 1'b0;
        @(negedge clk);
        chk("R10 mid-write reset bready", m_bready, 0);
        chk("R10 mid-write reset valids", {m_awvalid, m_wvalid}, 2'b00);
        rst = 1'b0; b_dly = 0;
        repeat (3) @(negedge clk);
        write_one(32'h0000_0300, 32'h3, 1'b0, "after reset");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule